// File: doc/BRIEF.md
# 128-bit Packed SIMD Integer ALU

This block is a single-cycle integer datapath. It treats two 128-bit operands as a row of equal-width lanes. A two-bit size field splits the row into sixteen bytes, eight halfwords or four words. One opcode is applied to every lane at the same time. The result is captured in a register and appears one clock after the request, together with a valid flag. No carry, borrow or shifted bit ever moves from one lane into its neighbour. Each lane therefore behaves like a narrow ALU of its own.

The opcode set covers wrapping and signed-saturating add and subtract, signed minimum and maximum, and saturating absolute value. It also has shifts that use one shared amount, bitwise AND/OR/XOR, and mask-producing compares. Two width-conversion families complete the set: a pack that narrows lanes from both operands into one row, and an extend that widens the low half of operand A. The block is meant to sit in the execute stage of a wide integer pipe. There the issuing logic supplies operands every cycle and marks real work with the valid input.

Top module: `simd_alu128`

## Requirements
- R1: Lane size `lane_sz` selects 8-bit lanes (0), 16-bit lanes (1) or 32-bit lanes (2 and 3). Opcode 0 (add) and opcode 1 (subtract, A minus B) wrap modulo the lane width, and no carry crosses a lane boundary.
- R2: Opcodes 2 (add) and 3 (subtract) treat lanes as two's-complement and clamp an overflowing result to the lane's largest positive or most negative value.
- R3: Opcode 4 returns the signed minimum of the A and B lanes, and opcode 5 returns the signed maximum.
- R4: Opcode 6 returns the absolute value of each A lane. The most negative lane value yields the largest positive value.
- R5: Opcodes 7 (logical left), 8 (logical right) and 9 (arithmetic right) shift every A lane by `shamt` ANDed with (lane width − 1).
- R6: Opcodes 10, 11 and 12 return the bitwise AND, OR and XOR of A and B.
- R7: Opcode 13 (equal) and opcode 14 (A signed-greater than B) set a lane to all ones when the condition holds and to all zeros otherwise.
- R8: Opcode 15 with size 1 or size 2/3 takes the low half of every A lane into bits 63:0 and the low half of every B lane into bits 127:64. In both halves, lane order is kept with lane 0 lowest.
- R9: Opcode 16 (sign) and opcode 17 (zero) extend the narrow lanes in A[63:0] into lanes of the selected width, which is 16 for size 1 and 32 for size 2/3.
- R10: After reset `out_valid` and `result` are 0. `out_valid` equals `in_valid` of the previous cycle. `result` changes only in the cycle after a valid request.
- R11: Opcodes 18 to 31 give a zero result, and so do opcodes 15 to 17 with size 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| lane_sz | input | 2 | Lane width select |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| shamt | input | 5 | Shared shift amount |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 128 | Registered lane-wise result |

## Verification
Some properties are checked on every cycle. The valid flag must follow the request by exactly one cycle, and the result must hold still after an idle cycle. Undefined opcodes must produce zero. Inside each lane, a saturating add or subtract may never flip the expected sign, and an absolute value may never come out negative. The exact lane values still need the bench scenarios: wrap-around without carry leakage, masking of the shift amount, lane ordering for pack and extend, and compare masks. The bench checks these against hand-worked corner cases and against a lane-by-lane model, sweeping every opcode and size.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_W_A = 2'd3
    } lane_sz_e;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_ADDS  = 5'd2,
        OP_SUBS  = 5'd3,
        OP_MIN   = 5'd4,
        OP_MAX   = 5'd5,
        OP_ABS   = 5'd6,
        OP_SLL   = 5'd7,
        OP_SRL   = 5'd8,
        OP_SRA   = 5'd9,
        OP_AND   = 5'd10,
        OP_OR    = 5'd11,
        OP_XOR   = 5'd12,
        OP_CMPEQ = 5'd13,
        OP_CMPGT = 5'd14,
        OP_PACK  = 5'd15,
        OP_EXTS  = 5'd16,
        OP_EXTU  = 5'd17
    } op_e;

    localparam logic [4:0] OP_LAST = OP_EXTU;

endpackage

// File: rtl/simd_lane_unit.sv
// One row of equal-width lanes; every lane computes the same opcode.
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int W   = 8,
    parameter int DW  = 128,
    parameter int SHW = 5
) (
    input  logic [4:0]     op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic [SHW-1:0] shamt,
    output logic [DW-1:0]  res
);
    localparam int NL = DW / W;
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

    logic [SHW-1:0] sh;
    assign sh = shamt & SHW'(W - 1);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic signed [W-1:0] la;
        logic signed [W-1:0] lb;
        logic signed [W:0]   sum;
        logic signed [W:0]   dif;
        logic [W-1:0]        r;

        assign la  = opa[i*W +: W];
        assign lb  = opb[i*W +: W];
        assign sum = {la[W-1], la} + {lb[W-1], lb};
        assign dif = {la[W-1], la} - {lb[W-1], lb};

        always_comb begin
            case (op_e'(op))
                OP_ADD:   r = sum[W-1:0];
                OP_SUB:   r = dif[W-1:0];
                OP_ADDS:  r = (sum[W] != sum[W-1]) ? (sum[W] ? MINN : MAXP) : sum[W-1:0];
                OP_SUBS:  r = (dif[W] != dif[W-1]) ? (dif[W] ? MINN : MAXP) : dif[W-1:0];
                OP_MIN:   r = (la < lb) ? la : lb;
                OP_MAX:   r = (la > lb) ? la : lb;
                OP_ABS: begin
                    if (!la[W-1])        r = la;
                    else if (la == MINN) r = MAXP;
                    else                 r = -la;
                end
                OP_SLL:   r = la << sh;
                OP_SRL:   r = $unsigned(la) >> sh;
                OP_SRA:   r = la >>> sh;
                OP_AND:   r = la & lb;
                OP_OR:    r = la | lb;
                OP_XOR:   r = la ^ lb;
                OP_CMPEQ: r = (la == lb) ? {W{1'b1}} : {W{1'b0}};
                OP_CMPGT: r = (la > lb)  ? {W{1'b1}} : {W{1'b0}};
                default:  r = '0;
            endcase
        end

        // lane-level checks on the arithmetic corner cases
        always_comb begin
            if (op == OP_ABS) begin
                p_abs_nonneg_r4: assert (r[W-1] == 1'b0)
                    else $error("abs lane %0d negative", i);
            end
            if (op == OP_ADDS && la[W-1] == lb[W-1]) begin
                p_adds_sign_r2: assert (r[W-1] == la[W-1])
                    else $error("saturating add lane %0d flipped sign", i);
            end
            if (op == OP_SUBS && la[W-1] != lb[W-1]) begin
                p_subs_sign_r2: assert (r[W-1] == la[W-1])
                    else $error("saturating sub lane %0d flipped sign", i);
            end
        end

        assign res[i*W +: W] = r;
    end

endmodule

// File: rtl/simd_pack_unit.sv
// Width conversion: narrowing pack and widening extend for 16- and 32-bit lanes.
module simd_pack_unit
    import simd_pkg::*;
#(
    parameter int DW = 128
) (
    input  logic [4:0]    op,
    input  logic [1:0]    lane_sz,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);
    localparam int NV = 2;   // 16-bit and 32-bit wide-lane variants

    logic [DW-1:0] pk  [NV];
    logic [DW-1:0] exs [NV];
    logic [DW-1:0] exu [NV];

    for (genvar k = 0; k < NV; k++) begin : g_var
        localparam int WW = 16 << k;
        localparam int HW = WW / 2;
        localparam int NL = DW / WW;
        logic [DW-1:0] pk_w;
        logic [DW-1:0] exs_w;
        logic [DW-1:0] exu_w;

        for (genvar i = 0; i < NL; i++) begin : g_ln
            logic [HW-1:0] src;
            assign src = opa[i*HW +: HW];
            assign pk_w[i*HW +: HW]        = opa[i*WW +: HW];
            assign pk_w[DW/2 + i*HW +: HW] = opb[i*WW +: HW];
            assign exs_w[i*WW +: WW]       = {{HW{src[HW-1]}}, src};
            assign exu_w[i*WW +: WW]       = {{HW{1'b0}}, src};
        end

        assign pk[k]  = pk_w;
        assign exs[k] = exs_w;
        assign exu[k] = exu_w;
    end

    logic unused_hi;
    assign unused_hi = ^{opa, opb};

    int sel;
    always_comb begin
        sel = (lane_sz == SZ_H) ? 0 : 1;
        res = '0;
        if (lane_sz != SZ_B) begin
            case (op_e'(op))
                OP_PACK: res = pk[sel];
                OP_EXTS: res = exs[sel];
                OP_EXTU: res = exu[sel];
                default: res = '0;
            endcase
        end
    end

endmodule

// File: rtl/simd_alu128.sv
module simd_alu128
    import simd_pkg::*;
#(
    parameter int DW  = 128,
    parameter int SHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [4:0]     op,
    input  logic [1:0]     lane_sz,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic [SHW-1:0] shamt,
    output logic           out_valid,
    output logic [DW-1:0]  result
);
    localparam int NSZ = 3;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] lane_res [NSZ];
    logic [DW-1:0] conv_res;

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        simd_lane_unit #(
            .W   (8 << g),
            .DW  (DW),
            .SHW (SHW)
        ) u_lanes (
            .op    (op),
            .opa   (opa),
            .opb   (opb),
            .shamt (shamt),
            .res   (lane_res[g])
        );
    end

    simd_pack_unit #(
        .DW (DW)
    ) u_conv (
        .op      (op),
        .lane_sz (lane_sz),
        .opa     (opa),
        .opb     (opb),
        .res     (conv_res)
    );

    logic [DW-1:0] sel_d;
    logic          is_conv_d;

    always_comb begin
        case (lane_sz_e'(lane_sz))
            SZ_B:    sel_d = lane_res[0];
            SZ_H:    sel_d = lane_res[1];
            default: sel_d = lane_res[2];
        endcase
        is_conv_d = (op == OP_PACK) || (op == OP_EXTS) || (op == OP_EXTU);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = is_conv_d ? conv_res : sel_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    p_vld_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_LAST) |=> (result == '0));

endmodule

// File: tb/sim_simd_alu128.sv
`timescale 1ns/1ps
module sim_simd_alu128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   op = '0;
    logic [1:0]   lane_sz = '0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [4:0]   shamt = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    longint unsigned rng = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;

    simd_alu128 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .lane_sz   (lane_sz),
        .opa       (opa),
        .opb       (opb),
        .shamt     (shamt),
        .out_valid (out_valid),
        .result    (result)
    );

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one request, sampled at the negedge after the capturing edge
    task automatic exec(input logic [4:0] o, input logic [1:0] s,
                        input logic [127:0] a, input logic [127:0] b, input logic [4:0] sh);
        @(negedge clk);
        op = o; lane_sz = s; opa = a; opb = b; shamt = sh; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 valid after request", 128'(out_valid), 128'd1);
    endtask

    function automatic longint clampv(longint v, longint mx, longint mn);
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    // lane-by-lane model written from the requirements
    function automatic logic [127:0] model(int o, int s, logic [127:0] a, logic [127:0] b, int sh);
        int w = (s == 0) ? 8 : (s == 1) ? 16 : 32;
        int n = 128 / w;
        int hw = w / 2;
        int sa_amt = sh & (w - 1);
        longint mx = (longint'(1) << (w - 1)) - 1;
        longint mn = -(longint'(1) << (w - 1));
        logic [127:0] m  = (128'd1 << w) - 1;
        logic [127:0] hm = (128'd1 << hw) - 1;
        logic [127:0] r  = '0;
        if (o <= 14) begin
            for (int i = 0; i < n; i++) begin
                longint ua = longint'(64'((a >> (i*w)) & m));
                longint ub = longint'(64'((b >> (i*w)) & m));
                longint xa = (ua > mx) ? ua - (longint'(1) << w) : ua;
                longint xb = (ub > mx) ? ub - (longint'(1) << w) : ub;
                longint v;
                case (o)
                    0:  v = ua + ub;
                    1:  v = ua - ub;
                    2:  v = clampv(xa + xb, mx, mn);
                    3:  v = clampv(xa - xb, mx, mn);
                    4:  v = (xa < xb) ? xa : xb;
                    5:  v = (xa > xb) ? xa : xb;
                    6:  v = clampv((xa < 0) ? -xa : xa, mx, mn);
                    7:  v = ua << sa_amt;
                    8:  v = ua >> sa_amt;
                    9:  v = xa >>> sa_amt;
                    10: v = ua & ub;
                    11: v = ua | ub;
                    12: v = ua ^ ub;
                    13: v = (ua == ub) ? -1 : 0;
                    default: v = (xa > xb) ? -1 : 0;
                endcase
                r |= (128'(v) & m) << (i*w);
            end
        end else if (o == 15 && w > 8) begin
            for (int i = 0; i < n; i++) begin
                r |= ((a >> (i*w)) & hm) << (i*hw);
                r |= ((b >> (i*w)) & hm) << (64 + i*hw);
            end
        end else if ((o == 16 || o == 17) && w > 8) begin
            for (int i = 0; i < n; i++) begin
                logic [127:0] src = (a >> (i*hw)) & hm;
                if (o == 16 && src[hw-1]) src |= m & ~hm;
                r |= src << (i*w);
            end
        end
        return r;
    endfunction

    function automatic string req_of(int o);
        if (o <= 1)  return "R1";
        if (o <= 3)  return "R2";
        if (o <= 5)  return "R3";
        if (o == 6)  return "R4";
        if (o <= 9)  return "R5";
        if (o <= 12) return "R6";
        if (o <= 14) return "R7";
        if (o == 15) return "R8";
        if (o <= 17) return "R9";
        return "R11";
    endfunction

    function automatic logic [63:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    task automatic t_reset();
        chk("R10 reset valid", 128'(out_valid), 128'd0);
        chk("R10 reset result", result, 128'd0);
    endtask

    task automatic t_add_wrap();
        exec(5'd0, 2'd0, {16{8'hFF}}, 128'h01, 5'd0);
        chk("R1 byte wrap no carry", result, {{15{8'hFF}}, 8'h00});
        exec(5'd0, 2'd1, {8{16'hFFFF}}, 128'h01, 5'd0);
        chk("R1 half wrap no carry", result, {{7{16'hFFFF}}, 16'h0000});
        exec(5'd1, 2'd3, 128'h0, 128'h1, 5'd0);
        chk("R1 word sub borrow stays in lane", result, {96'h0, 32'hFFFF_FFFF});
    endtask

    task automatic t_sat();
        exec(5'd2, 2'd0, 128'h807F, 128'hFF01, 5'd0);
        chk("R2 byte saturating add", result, 128'h807F);
        exec(5'd3, 2'd1, 128'h7FFF_8000, 128'hFFFF_0001, 5'd0);
        chk("R2 half saturating sub", result, 128'h7FFF_8000);
    endtask

    task automatic t_minmax();
        exec(5'd4, 2'd0, 128'h7F80, 128'h80_7F, 5'd0);
        chk("R3 signed min", result, 128'h8080);
        exec(5'd5, 2'd0, 128'h7F80, 128'h80_7F, 5'd0);
        chk("R3 signed max", result, 128'h7F7F);
    endtask

    task automatic t_abs();
        exec(5'd6, 2'd2, 128'h80000000_FFFFFFFF_00000005_7FFFFFFF, 128'h0, 5'd0);
        chk("R4 abs with saturation", result, 128'h7FFFFFFF_00000001_00000005_7FFFFFFF);
    endtask

    task automatic t_shift();
        exec(5'd7, 2'd0, {16{8'h81}}, 128'h0, 5'd9);
        chk("R5 left shift amount masked", result, {16{8'h02}});
        exec(5'd9, 2'd1, {8{16'h8000}}, 128'h0, 5'd17);
        chk("R5 arithmetic right masked", result, {8{16'hC000}});
        exec(5'd8, 2'd1, {8{16'h8000}}, 128'h0, 5'd17);
        chk("R5 logical right masked", result, {8{16'h4000}});
    endtask

    task automatic t_logic();
        exec(5'd10, 2'd2, {4{32'hF0F0_F0F0}}, {4{32'hFF00_FF00}}, 5'd0);
        chk("R6 and", result, {4{32'hF000_F000}});
        exec(5'd12, 2'd0, {4{32'hF0F0_F0F0}}, {4{32'hFF00_FF00}}, 5'd0);
        chk("R6 xor independent of size", result, {4{32'h0FF0_0FF0}});
    endtask

    task automatic t_cmp();
        exec(5'd13, 2'd1, 128'h0005_0007, 128'h0005_0006, 5'd0);
        chk("R7 equal mask", result, {{6{16'hFFFF}}, 16'hFFFF, 16'h0000});
        exec(5'd14, 2'd0, 128'h01_80, 128'hFF_7F, 5'd0);
        chk("R7 signed greater mask", result, 128'hFF_00);
    endtask

    task automatic t_pack();
        exec(5'd15, 2'd1, {8{16'h1234}}, {8{16'hABCD}}, 5'd0);
        chk("R8 pack halves to bytes", result, {{8{8'hCD}}, {8{8'h34}}});
        exec(5'd15, 2'd2, 128'h44440004_33330003_22220002_11110001,
             128'h88880008_77770007_66660006_55550005, 5'd0);
        chk("R8 pack lane order", result, 128'h0008_0007_0006_0005_0004_0003_0002_0001);
    endtask

    task automatic t_extend();
        exec(5'd16, 2'd1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_7F80}, 128'h0, 5'd0);
        chk("R9 sign extend bytes", result, {96'h0, 16'h007F, 16'hFF80});
        exec(5'd17, 2'd2, {64'h0, 64'h0000_0000_8000_0001}, 128'h0, 5'd0);
        chk("R9 zero extend halves", result, {64'h0, 32'h0000_8000, 32'h0000_0001});
    endtask

    task automatic t_zero_cases();
        exec(5'd20, 2'd2, {4{32'h1234_5678}}, {4{32'h1111_1111}}, 5'd3);
        chk("R11 undefined opcode", result, 128'h0);
        exec(5'd15, 2'd0, {4{32'h1234_5678}}, {4{32'h1111_1111}}, 5'd0);
        chk("R11 pack with byte size", result, 128'h0);
    endtask

    task automatic t_hold();
        logic [127:0] held;
        exec(5'd0, 2'd2, 128'h5, 128'h6, 5'd0);
        held = result;
        chk("R10 result before idle", held, 128'hB);
        @(negedge clk);
        op = 5'd11; opa = '1; opb = '1;
        repeat (3) @(negedge clk);
        chk("R10 valid low when idle", 128'(out_valid), 128'd0);
        chk("R10 result held when idle", result, held);
    endtask

    task automatic t_sweep();
        logic [127:0] pat [6];
        pat[0] = '1;
        pat[1] = {16{8'h80}};
        pat[2] = {16{8'h7F}};
        pat[3] = {next_rand(), next_rand()};
        pat[4] = {next_rand(), next_rand()};
        pat[5] = {next_rand(), next_rand()};
        for (int p = 0; p < 6; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 19; o++) begin
                    logic [127:0] b = pat[(p + 3) % 6] ^ {next_rand(), next_rand()};
                    int sh = int'(next_rand() & 64'h1F);
                    exec(5'(o), 2'(s), pat[p], b, 5'(sh));
                    chk(req_of(o), result, model(o, s, pat[p], b, sh));
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_wrap();
        t_sat();
        t_minmax();
        t_abs();
        t_shift();
        t_logic();
        t_cmp();
        t_pack();
        t_extend();
        t_zero_cases();
        t_hold();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule